// File: doc/BRIEF.md
# Shared Converter Sequencer with Register File

This block sits between a register bus and one external analog-to-digital converter that three conversion engines share: touch, battery and auxiliary. Software sets an engine's start bit. The block then waits for a tick of its divided conversion clock and raises a request on the converter port, tagged with the engine. It holds that request until the converter answers with a done pulse and a 12-bit sample. The sample is stored in the engine's result register.

A touch run takes two samples, one per slot, and each sample carries a type flag. Battery and auxiliary runs take one sample. When a run finishes, the engine's start bit clears by itself and its done flag in the status register sets. Two pen event inputs set their own status flags. A mask register, where 1 blocks a source, selects which flags drive the single registered interrupt output.

All registers sit at word-aligned byte addresses. A write changes only the byte lanes that its byte enables select, and reads return data in the same cycle.

Top module: `adc_hub`

## Requirements
- R1: After reset the start register (0x00), the status register (0x0C) and all result registers read 0. The mask register (0x08) reads 0x1F, and irq_o is 0.
- R2: The configuration register (0x04) keeps bits 12:10 (sample count), 8:5 (clock divider) and 4 (battery range), and every other bit reads 0. A write updates only the byte lanes whose bus_be_i bit is set.
- R3: Start bits are touch = bit 2, battery = bit 1 and auxiliary = bit 0. When an engine's run completes, its start bit clears and the status done bit at the same position sets.
- R4: Engines run in fixed priority: touch, then battery, then auxiliary. Only one request is open at a time. conv_req_o stays high until conv_done_i arrives. conv_sel_o is 2 for touch, 1 for battery and 0 for auxiliary.
- R5: conv_tick_o pulses once every (divider + 1) clock cycles. conv_req_o rises only in the cycle after a tick.
- R6: The battery result (0x1C) and the auxiliary result (0x20) hold the sample in bits 11:0, and their upper bits read 0. Bus writes to result registers have no effect.
- R7: A touch run issues slot 0 and then slot 1 (conv_slot_o). The touch result (0x18) holds the slot 0 sample in bits 11:0 with its type flag at bit 15, and the slot 1 sample in bits 27:16 with its type flag at bit 31. The touch done bit sets only after slot 1.
- R8: Writing 1 to a status bit clears it. pen_down_i sets status bit 4 and pen_up_i sets status bit 3. If a flag is set and cleared in the same cycle, the set wins.
- R9: A mask bit of 1 blocks the matching status bit. irq_o is the registered OR of the unmasked status bits, so it follows a change of status or mask one cycle later.
- R10: If software clears a start bit while that engine's request is open, the run is aborted. The late sample is discarded, no status bit sets, and the result register keeps its old value.
- R11: conv_range_o follows configuration bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word-aligned byte address |
| bus_be_i | input | 4 | Byte lane enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| pen_down_i | input | 1 | Pen-down event, sets status bit 4 |
| pen_up_i | input | 1 | Pen-up event, sets status bit 3 |
| conv_tick_o | output | 1 | Divided conversion clock tick |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_sel_o | output | 2 | Engine of the open request |
| conv_slot_o | output | 1 | Touch sample slot of the open request |
| conv_range_o | output | 1 | Battery measurement range |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | 12 | Converted sample |
| conv_type_i | input | 1 | Type flag of the sample |
| irq_o | output | 1 | Combined interrupt |

## Verification
Register reads have no latency, so a register's value is checked on the first falling edge after the rising edge that commits the write. irq_o is due one rising edge later. The bench checks that it is unchanged at the first falling edge after a status or mask change and has its new value at the second. The latency of a conversion run depends on the divider and on the converter model's delay, so the bench polls the start register until the bits it set have cleared, and only then reads the results and the status. The request order is logged by the converter model when it accepts each request and is compared with the priority order for the start mask.

// File: rtl/adc_hub_pkg.sv
package adc_hub_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int BE_W     = DATA_W / 8;
  localparam int NUM_ENG  = 3;
  localparam int ENG_W    = $clog2(NUM_ENG);
  localparam int STS_W    = NUM_ENG + 2;
  localparam int DIV_W    = 4;

  localparam logic [ADDR_W-1:0] OFS_EN  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_MSK = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_STS = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_TCH = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_BAT = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_AUX = 6'h20;

  localparam int ENG_AUX = 0;
  localparam int ENG_BAT = 1;
  localparam int ENG_TCH = 2;

  localparam int CFG_RANGE  = 4;
  localparam int CFG_DIV_LO = 5;
  localparam logic [DATA_W-1:0] CFG_KEEP = 32'h0000_1DF0;

  localparam int TCH_HI_LO = 16;
  localparam int TCH_TY0   = 15;
  localparam int TCH_TY1   = 31;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BUSY = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_hub_clkdiv.sv
module adc_hub_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (cnt_q == '0) cnt_q <= div_i;
    else                  cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/adc_hub_seq.sv
module adc_hub_seq
  import adc_hub_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [NUM_ENG-1:0] en_i,
  input  logic               conv_done_i,
  output logic               conv_req_o,
  output logic [ENG_W-1:0]   conv_sel_o,
  output logic               conv_slot_o,
  output logic               store_o,
  output logic               fin_o
);
  seq_state_e       state_q;
  logic [ENG_W-1:0] cur_q;
  logic             slot_q;
  logic             req_q;
  logic             pick_any;
  logic [ENG_W-1:0] pick_idx;
  logic             live;
  logic             two_slot;

  // higher index wins: touch > battery > auxiliary
  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < NUM_ENG; i++) begin
      if (en_i[i]) begin
        pick_any = 1'b1;
        pick_idx = ENG_W'(i);
      end
    end
  end

  assign live     = en_i[cur_q];
  assign two_slot = (cur_q == ENG_W'(ENG_TCH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cur_q   <= '0;
      slot_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (tick_i && pick_any) begin
          cur_q   <= pick_idx;
          slot_q  <= 1'b0;
          req_q   <= 1'b1;
          state_q <= SEQ_BUSY;
        end
        SEQ_BUSY: if (conv_done_i) begin
          req_q <= 1'b0;
          if (two_slot && !slot_q && live) begin
            slot_q  <= 1'b1;
            state_q <= SEQ_HOLD;
          end else begin
            state_q <= SEQ_IDLE;
          end
        end
        SEQ_HOLD: begin
          if (!live) begin
            state_q <= SEQ_IDLE;
          end else if (tick_i) begin
            req_q   <= 1'b1;
            state_q <= SEQ_BUSY;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign conv_req_o  = req_q;
  assign conv_sel_o  = cur_q;
  assign conv_slot_o = slot_q;
  assign store_o     = (state_q == SEQ_BUSY) && conv_done_i && live;
  assign fin_o       = store_o && (!two_slot || slot_q);
endmodule

// File: rtl/adc_hub_regs.sv
module adc_hub_regs
  import adc_hub_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [BE_W-1:0]    bus_be_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               pen_down_i,
  input  logic               pen_up_i,
  input  logic               store_i,
  input  logic               fin_i,
  input  logic [ENG_W-1:0]   eng_i,
  input  logic               slot_i,
  input  logic [SMP_W-1:0]   smp_i,
  input  logic               smp_type_i,
  output logic [NUM_ENG-1:0] en_o,
  output logic [DIV_W-1:0]   div_o,
  output logic               range_o,
  output logic [STS_W-1:0]   sts_o,
  output logic [STS_W-1:0]   msk_o
);
  logic [NUM_ENG-1:0] en_q;
  logic [DATA_W-1:0]  cfg_q;
  logic [STS_W-1:0]   msk_q;
  logic [STS_W-1:0]   sts_q;
  logic [SMP_W-1:0]   bat_q, aux_q, t0_q, t1_q;
  logic               ty0_q, ty1_q;
  logic [NUM_ENG-1:0] fin_vec;
  logic [STS_W-1:0]   sts_set, sts_clr;
  logic               wr;

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v,
                                                   input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
    return r;
  endfunction

  assign wr = bus_valid_i && bus_write_i;

  always_comb begin
    fin_vec = '0;
    for (int i = 0; i < NUM_ENG; i++)
      if (fin_i && eng_i == ENG_W'(i)) fin_vec[i] = 1'b1;
  end

  assign sts_set = {pen_down_i, pen_up_i, fin_vec};
  assign sts_clr = (wr && bus_addr_i == OFS_STS && bus_be_i[0]) ? bus_wdata_i[STS_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      cfg_q <= '0;
      msk_q <= '1;
      sts_q <= '0;
    end else begin
      // a software write to the start register overrides self-clearing
      if (wr && bus_addr_i == OFS_EN && bus_be_i[0]) en_q <= bus_wdata_i[NUM_ENG-1:0];
      else                                           en_q <= en_q & ~fin_vec;
      if (wr && bus_addr_i == OFS_CFG)
        cfg_q <= lane_merge(cfg_q, bus_wdata_i, bus_be_i) & CFG_KEEP;
      if (wr && bus_addr_i == OFS_MSK && bus_be_i[0]) msk_q <= bus_wdata_i[STS_W-1:0];
      sts_q <= (sts_q & ~sts_clr) | sts_set;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bat_q <= '0;
      aux_q <= '0;
      t0_q  <= '0;
      t1_q  <= '0;
      ty0_q <= 1'b0;
      ty1_q <= 1'b0;
    end else if (store_i) begin
      unique case (eng_i)
        ENG_W'(ENG_BAT): bat_q <= smp_i;
        ENG_W'(ENG_AUX): aux_q <= smp_i;
        ENG_W'(ENG_TCH): begin
          if (slot_i) begin
            t1_q  <= smp_i;
            ty1_q <= smp_type_i;
          end else begin
            t0_q  <= smp_i;
            ty0_q <= smp_type_i;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_EN:  bus_rdata_o[NUM_ENG-1:0] = en_q;
      OFS_CFG: bus_rdata_o = cfg_q;
      OFS_MSK: bus_rdata_o[STS_W-1:0] = msk_q;
      OFS_STS: bus_rdata_o[STS_W-1:0] = sts_q;
      OFS_BAT: bus_rdata_o[SMP_W-1:0] = bat_q;
      OFS_AUX: bus_rdata_o[SMP_W-1:0] = aux_q;
      OFS_TCH: begin
        bus_rdata_o[SMP_W-1:0]             = t0_q;
        bus_rdata_o[TCH_TY0]               = ty0_q;
        bus_rdata_o[TCH_HI_LO +: SMP_W]    = t1_q;
        bus_rdata_o[TCH_TY1]               = ty1_q;
      end
      default: bus_rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign div_o   = cfg_q[CFG_DIV_LO +: DIV_W];
  assign range_o = cfg_q[CFG_RANGE];
  assign sts_o   = sts_q;
  assign msk_o   = msk_q;
endmodule

// File: rtl/adc_hub.sv
module adc_hub
  import adc_hub_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BE_W-1:0]   bus_be_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              pen_down_i,
  input  logic              pen_up_i,
  output logic              conv_tick_o,
  output logic              conv_req_o,
  output logic [ENG_W-1:0]  conv_sel_o,
  output logic              conv_slot_o,
  output logic              conv_range_o,
  input  logic              conv_done_i,
  input  logic [SMP_W-1:0]  conv_data_i,
  input  logic              conv_type_i,
  output logic              irq_o
);
  logic [NUM_ENG-1:0] en_w;
  logic [DIV_W-1:0]   div_w;
  logic [STS_W-1:0]   sts_w, msk_w;
  logic               store_w, fin_w;
  logic               irq_q;

  adc_hub_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_w),
    .tick_o (conv_tick_o)
  );

  adc_hub_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (conv_tick_o),
    .en_i        (en_w),
    .conv_done_i (conv_done_i),
    .conv_req_o  (conv_req_o),
    .conv_sel_o  (conv_sel_o),
    .conv_slot_o (conv_slot_o),
    .store_o     (store_w),
    .fin_o       (fin_w)
  );

  adc_hub_regs #(.SMP_W(SMP_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_be_i    (bus_be_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pen_down_i  (pen_down_i),
    .pen_up_i    (pen_up_i),
    .store_i     (store_w),
    .fin_i       (fin_w),
    .eng_i       (conv_sel_o),
    .slot_i      (conv_slot_o),
    .smp_i       (conv_data_i),
    .smp_type_i  (conv_type_i),
    .en_o        (en_w),
    .div_o       (div_w),
    .range_o     (conv_range_o),
    .sts_o       (sts_w),
    .msk_o       (msk_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(sts_w & ~msk_w);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/adc_hub_chk.sv
module adc_hub_chk
  import adc_hub_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_valid_i,
  input logic               bus_write_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [BE_W-1:0]    bus_be_i,
  input logic               conv_tick_o,
  input logic               conv_req_o,
  input logic [ENG_W-1:0]   conv_sel_o,
  input logic               conv_done_i,
  input logic               irq_o,
  input logic [NUM_ENG-1:0] en_w,
  input logic [STS_W-1:0]   sts_w,
  input logic [STS_W-1:0]   msk_w,
  input logic               fin_w
);
  logic en_wr;
  assign en_wr = bus_valid_i && bus_write_i && bus_addr_i == OFS_EN && bus_be_i[0];

  // R5
  req_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_req_o) |-> $past(conv_tick_o));

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o && !conv_done_i |=> conv_req_o);

  // R4
  aux_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_req_o) && conv_sel_o == ENG_W'(ENG_AUX) |-> $past(en_w[ENG_TCH:ENG_BAT]) == 2'b00);

  // R3
  fin_clears_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_w && !en_wr |=> !en_w[$past(conv_sel_o)]);

  // R9
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_w & ~msk_w) == '0 |=> !irq_o);

  // R9
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_w & ~msk_w) != '0 |=> irq_o);
endmodule

bind adc_hub adc_hub_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .bus_be_i    (bus_be_i),
  .conv_tick_o (conv_tick_o),
  .conv_req_o  (conv_req_o),
  .conv_sel_o  (conv_sel_o),
  .conv_done_i (conv_done_i),
  .irq_o       (irq_o),
  .en_w        (en_w),
  .sts_w       (sts_w),
  .msk_w       (msk_w),
  .fin_w       (fin_w)
);

// File: tb/adc_hub_test.sv
`timescale 1ns/1ps
module adc_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        pen_down = 1'b0, pen_up = 1'b0;
  logic        conv_tick, conv_req, conv_slot, conv_range, irq;
  logic [1:0]  conv_sel;
  logic        conv_done = 1'b0, conv_type = 1'b0;
  logic [11:0] conv_data = '0;

  int n_chk = 0, n_err = 0;
  int lat_cfg = 2, cnt = 0;
  bit serving = 0;
  int log_code[16];
  int log_n = 0;
  logic [11:0] exp_bat = '0, exp_aux = '0, exp_t0 = '0, exp_t1 = '0;
  logic        exp_ty0 = 1'b0, exp_ty1 = 1'b0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  adc_hub uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_be_i(bus_be), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pen_down_i(pen_down), .pen_up_i(pen_up),
    .conv_tick_o(conv_tick), .conv_req_o(conv_req), .conv_sel_o(conv_sel),
    .conv_slot_o(conv_slot), .conv_range_o(conv_range),
    .conv_done_i(conv_done), .conv_data_i(conv_data), .conv_type_i(conv_type),
    .irq_o(irq)
  );

  // converter model: accepts an open request, answers after lat_cfg cycles
  always @(negedge clk) begin
    if (conv_done) begin
      conv_done = 1'b0;
    end else if (serving) begin
      if (cnt == 0) begin
        serving   = 0;
        conv_data = 12'($urandom);
        conv_type = 1'($urandom);
        conv_done = 1'b1;
        case (conv_sel)
          2'd1: exp_bat = conv_data;
          2'd0: exp_aux = conv_data;
          default: if (conv_slot) begin exp_t1 = conv_data; exp_ty1 = conv_type; end
                   else begin exp_t0 = conv_data; exp_ty0 = conv_type; end
        endcase
      end else cnt--;
    end else if (conv_req && rst_n) begin
      serving = 1;
      cnt = lat_cfg;
      if (log_n < 16) log_code[log_n] = int'(conv_sel) * 2 + int'(conv_slot);
      log_n++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_valid = 1'b1; bus_write = 1'b0;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] e;
    for (int i = 0; i < 5000; i++) begin
      rd(6'h00, e);
      if (e[2:0] == 3'b000) return;
    end
    check("R3 timeout", e, 32'h0);
  endtask

  function automatic logic [31:0] tch_word();
    logic [31:0] w;
    w = '0;
    w[11:0] = exp_t0; w[15] = exp_ty0;
    w[27:16] = exp_t1; w[31] = exp_ty1;
    return w;
  endfunction

  task automatic run_mask(input logic [2:0] m, input string tag);
    int exp_codes[4];
    int ne;
    logic [31:0] e;
    ne = 0;
    if (m[2]) begin exp_codes[ne] = 4; ne++; exp_codes[ne] = 5; ne++; end
    if (m[1]) begin exp_codes[ne] = 2; ne++; end
    if (m[0]) begin exp_codes[ne] = 0; ne++; end
    log_n = 0;
    wr(6'h00, {29'd0, m}, 4'h1);
    wait_idle();
    check({tag, " R4 count"}, log_n, ne);
    for (int i = 0; i < ne && i < 16; i++) check({tag, " R4 order"}, log_code[i], exp_codes[i]);
    rd(6'h0C, e); check({tag, " R3 status"}, e, {29'd0, m});
    if (m[1]) begin rd(6'h1C, e); check({tag, " R6 battery"}, e, {20'd0, exp_bat}); end
    if (m[0]) begin rd(6'h20, e); check({tag, " R6 aux"}, e, {20'd0, exp_aux}); end
    if (m[2]) begin rd(6'h18, e); check({tag, " R7 touch"}, e, tch_word()); end
    wr(6'h0C, 32'hFF, 4'h1);
  endtask

  task automatic tick_gap(output int g);
    g = 0;
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 40 && !conv_tick; i++) @(negedge clk);
      @(negedge clk);
    end
    for (int i = 0; i < 40 && !conv_tick; i++) begin @(negedge clk); g++; end
    g++;
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [11:0] old;
    int g;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    check("R1 irq", irq, 1'b0);
    rd(6'h00, v); check("R1 enable", v, 32'h0);
    rd(6'h08, v); check("R1 mask", v, 32'h1F);
    rd(6'h0C, v); check("R1 status", v, 32'h0);
    rd(6'h18, v); check("R1 touch", v, 32'h0);
    rd(6'h1C, v); check("R1 battery", v, 32'h0);

    // R2
    wr(6'h04, 32'hFFFF_FFFF, 4'hF);
    rd(6'h04, v); check("R2 cfg keep", v, 32'h0000_1DF0);
    wr(6'h04, 32'h0, 4'h2);
    rd(6'h04, v); check("R2 byte lane", v, 32'h0000_00F0);

    // R11
    wr(6'h04, 32'h10, 4'hF);
    check("R11 range high", conv_range, 1'b1);
    wr(6'h04, 32'h0, 4'hF);
    check("R11 range low", conv_range, 1'b0);

    // R5
    wr(6'h04, 32'h60, 4'hF);
    tick_gap(g); check("R5 div3", g, 4);
    wr(6'h04, 32'h0, 4'hF);
    tick_gap(g); check("R5 div0", g, 1);
    wr(6'h04, 32'h1E0, 4'hF);
    tick_gap(g); check("R5 div15", g, 16);

    // R3 R4 R6 R7 directed, all engines at once
    wr(6'h04, 32'h20, 4'hF);
    run_mask(3'b111, "all");

    // R6 result writes ignored
    wr(6'h1C, 32'hFFFF_FFFF, 4'hF);
    rd(6'h1C, v); check("R6 write ignored", v, {20'd0, exp_bat});

    // R8
    wr(6'h0C, 32'hFF, 4'h1);
    @(negedge clk); pen_up = 1'b1;
    @(negedge clk); pen_up = 1'b0;
    rd(6'h0C, v); check("R8 pen_up", v, 32'h08);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h10; bus_be = 4'h1;
    pen_down = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; pen_down = 1'b0;
    rd(6'h0C, v); check("R8 set wins", v, 32'h18);
    wr(6'h0C, 32'h08, 4'h1);
    rd(6'h0C, v); check("R8 w1c", v, 32'h10);
    wr(6'h0C, 32'hFF, 4'h1);
    rd(6'h0C, v); check("R8 clear all", v, 32'h0);

    // R9
    wr(6'h08, 32'h0, 4'h1);
    check("R9 idle", irq, 1'b0);
    @(negedge clk); pen_up = 1'b1;
    @(negedge clk); pen_up = 1'b0;
    check("R9 lag", irq, 1'b0);
    @(negedge clk);
    check("R9 raise", irq, 1'b1);
    wr(6'h08, 32'h08, 4'h1);
    check("R9 mask lag", irq, 1'b1);
    @(negedge clk);
    check("R9 masked", irq, 1'b0);
    wr(6'h08, 32'h1F, 4'h1);
    wr(6'h0C, 32'hFF, 4'h1);

    // R10 abort while request open
    old = exp_aux;
    lat_cfg = 20;
    wr(6'h00, 32'h1, 4'h1);
    for (int i = 0; i < 100 && !conv_req; i++) @(negedge clk);
    wr(6'h00, 32'h0, 4'h1);
    repeat (30) @(negedge clk);
    exp_aux = old;
    lat_cfg = 2;
    rd(6'h0C, v); check("R10 no status", v, 32'h0);
    rd(6'h20, v); check("R10 result kept", v, {20'd0, old});
    rd(6'h00, v); check("R10 enable", v, 32'h0);

    // random mixes
    for (int it = 0; it < 20; it++) begin
      logic [2:0] m;
      m = 3'($urandom_range(1, 7));
      lat_cfg = $urandom_range(0, 5);
      wr(6'h04, {23'd0, 4'($urandom_range(0, 3)), 5'd0}, 4'hF);
      run_mask(m, "rand");
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule